// File: doc/BRIEF.md
# Conversion Result Buffer with Byte Readout

This block sits between an analog-to-digital converter producing 13-bit two's-complement results and an 8-bit host bus. Each completion pulse from the converter delivers one result. The block widens it to a 16-bit word by sign extension and queues it in a first-in first-out store of 256 entries.

The host drains the store one word at a time. It reads the low byte first and then the high byte, and the second read removes the word. Three status outputs report the state of the store. The first says that data is waiting. The second is a sticky flag raised when a result had to be thrown away because the store was full. The third is an interrupt request, gated by an enable input, that stays asserted while data is waiting. A clear strobe empties the store and drops the error flag.

Top module: `adc_result_fifo`

## Requirements
- R1: The store keeps up to 256 results. All 256 are read back in arrival order, with no loss and no overflow flag.
- R2: Each stored word equals the 13-bit input sign-extended to 16 bits. Bits 15..13 copy input bit 12. For example, input 0x1000 reads back as 0xF000 and input 0x0FFF reads back as 0x0FFF.
- R3: A read with `rd_hi`=0 returns bits 7..0 of the oldest word and arms the word. A later read with `rd_hi`=1 returns bits 15..8 and removes the word. The next read then sees the following word.
- R4: A read with `rd_hi`=1 while the oldest word is not armed returns bits 15..8 of that word and does not remove it.
- R5: `data_avail` is 1 exactly when at least one word is stored. After reset it is 0, and `overflow` is 0.
- R6: A result that arrives while 256 words are stored, with no removal in the same cycle, is discarded. It sets `overflow`, leaves the stored words unchanged, and `overflow` stays 1 until a clear.
- R7: `clr_stb` empties the store, clears `overflow` and disarms any pending low-byte read. It overrides a push or a read in the same cycle.
- R8: `irq` is 1 exactly when `irq_en` is 1 and `data_avail` is 1. It drops after the read that empties the store.
- R9: A read while the store is empty returns 0x00 and changes neither the store, nor the flags, nor the armed state.
- R10: A result that arrives in the same cycle as a removal from a full store is accepted, and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 13 | Conversion result, two's complement |
| res_valid | input | 1 | One-cycle pulse marking a new result |
| rd_stb | input | 1 | Host read strobe, one cycle per byte |
| rd_hi | input | 1 | Byte select for the read: 0 for low byte, 1 for high byte |
| clr_stb | input | 1 | Clear strobe that empties the store and clears the error flag |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Byte of the oldest word selected by `rd_hi`, 0x00 when empty |
| data_avail | output | 1 | At least one word is stored |
| overflow | output | 1 | Sticky flag for a discarded result |
| irq | output | 1 | Interrupt request |

## Verification
Random traffic with a balanced push and read mix exercises the ordering, the sign extension and the pairing of low and high byte reads. The reads include stray high-byte reads and repeated low-byte reads, which separate the armed state from a plain toggle. A push-heavy random phase, together with a directed fill to 256 and then 257 entries, shows the boundary between a full store and a lost result. A read-back after the overflow shows that the lost result did not overwrite anything. A high-byte read and a push in the same cycle on a full store separate "full" from "full with a removal pending". Clears arrive in the middle of traffic and on a store with an armed low byte, and reads are made on an empty store. Together these check that the clear overrides other activity and that empty reads leave no trace.

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int IN_W  = 13,
  parameter int DEPTH = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] res_data,
  input  logic            res_valid,
  input  logic            rd_stb,
  input  logic            rd_hi,
  input  logic            clr_stb,
  input  logic            irq_en,
  output logic [7:0]      rd_data,
  output logic            data_avail,
  output logic            overflow,
  output logic            irq
);
  localparam int WORD_W = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              lo_armed;

  wire               empty   = (count == '0);
  wire               full    = (count == FULL_CNT);
  wire [WORD_W-1:0]  head    = mem[rd_ptr];
  wire [WORD_W-1:0]  ext     = {{(WORD_W-IN_W){res_data[IN_W-1]}}, res_data};
  wire               rd_ok   = rd_stb && !empty;
  wire               pop     = rd_ok && rd_hi && lo_armed;
  wire               push    = res_valid && (!full || pop);
  wire               discard = res_valid && full && !pop;

  assign rd_data    = empty ? 8'h00 : (rd_hi ? head[15:8] : head[7:0]);
  assign data_avail = !empty;
  assign irq        = irq_en && data_avail;

  always_ff @(posedge clk) begin
    if (push && !clr_stb) mem[wr_ptr] <= ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_stb) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      lo_armed <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (rd_ok) lo_armed <= !rd_hi;
      if (discard) overflow <= 1'b1;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_push_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !clr_stb) |=> data_avail);

  assert_hi_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_hi && !lo_armed && !res_valid && !clr_stb) |=> $stable(count));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_stb) |=> overflow);

  assert_overflow_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(count) == FULL_CNT));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (!data_avail && !overflow && !irq));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_avail && !res_valid && !clr_stb) |=> (!data_avail && $stable(overflow) && !lo_armed));

  assert_pop_at_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && res_valid && !clr_stb) |=> (full && $stable(overflow)));
endmodule

// File: tb/test_adc_result_fifo.sv
module test_adc_result_fifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] res_data = '0;
  logic        res_valid = 0, rd_stb = 0, rd_hi = 0, clr_stb = 0, irq_en = 0;
  logic [7:0]  rd_data;
  logic        data_avail, overflow, irq;

  adc_result_fifo i_adc_result_fifo (
    .clk, .rst_n, .res_data, .res_valid, .rd_stb, .rd_hi, .clr_stb, .irq_en,
    .rd_data, .data_avail, .overflow, .irq
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mq[$];
  bit m_armed = 0, m_ovf = 0;

  function automatic logic [15:0] sext(input logic [12:0] d);
    return {{3{d[12]}}, d};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [12:0] d, input bit rd, input bit hi,
                      input bit clr, input bit ien, input string rtag);
    bit pop;
    @(negedge clk);
    res_valid = v; res_data = d; rd_stb = rd; rd_hi = hi; clr_stb = clr; irq_en = ien;
    #1;
    chk("R5 data_avail", data_avail, mq.size() != 0);
    chk("R6 overflow", overflow, m_ovf);
    chk("R8 irq", irq, ien && mq.size() != 0);
    if (rd) begin
      if (mq.size() == 0) chk("R9 empty read", rd_data, 0);
      else chk(rtag, rd_data, hi ? mq[0][15:8] : mq[0][7:0]);
    end
    @(posedge clk);
    if (clr) begin
      mq.delete(); m_ovf = 0; m_armed = 0;
    end else begin
      pop = rd && mq.size() != 0 && hi && m_armed;
      if (rd && mq.size() != 0) m_armed = !hi;
      if (pop) void'(mq.pop_front());
      if (v) begin
        if (mq.size() < 256) mq.push_back(sext(d));
        else m_ovf = 1;
      end
    end
  endtask

  task automatic idle(input bit ien);
    step(0, '0, 0, 0, 0, ien, "R3");
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    irq_en = 1; #1;
    chk("R5 reset data_avail", data_avail, 0);
    chk("R5 reset overflow", overflow, 0);
    chk("R8 reset irq", irq, 0);

    step(0, '0, 1, 0, 0, 1, "R9");
    step(0, '0, 1, 1, 0, 1, "R9");
    step(1, 13'h1000, 0, 0, 0, 1, "R2");
    step(1, 13'h0FFF, 0, 0, 0, 1, "R2");
    step(0, '0, 1, 1, 0, 1, "R4 high without low");
    chk("R4 still two", mq.size(), 2);
    step(0, '0, 1, 0, 0, 1, "R2 neg low");
    step(0, '0, 1, 1, 0, 1, "R2 neg high 0xF0");
    step(0, '0, 1, 0, 0, 1, "R2 pos low");
    step(0, '0, 1, 0, 0, 1, "R3 repeated low");
    step(0, '0, 1, 1, 0, 1, "R2 pos high 0x0F");
    idle(1);
    step(0, '0, 1, 0, 0, 1, "R9");
    idle(1);

    for (int i = 0; i < 256; i++) step(1, 13'(i * 29 + 7), 0, 0, 0, 0, "R1");
    idle(1);
    chk("R1 full no overflow", overflow, 0);
    step(1, 13'h0AAA, 0, 0, 0, 1, "R6");
    idle(1);
    chk("R6 overflow set", overflow, 1);
    step(0, '0, 1, 0, 0, 1, "R6 head unchanged low");
    step(1, 13'h1555, 1, 1, 0, 1, "R10 pop with push at full");
    chk("R10 still 256", mq.size(), 256);
    for (int i = 0; i < 256; i++) begin
      step(0, '0, 1, 0, 0, 1, "R1 drain low");
      step(0, '0, 1, 1, 0, 1, "R1 drain high");
    end
    idle(1);
    chk("R8 irq drops when empty", irq, 0);
    chk("R6 still sticky", overflow, 1);

    step(1, 13'h0123, 0, 0, 0, 1, "R7");
    step(0, '0, 1, 0, 0, 1, "R7 arm");
    step(1, 13'h0456, 0, 0, 1, 1, "R7 clear over push");
    idle(1);
    chk("R7 empty after clear", data_avail, 0);
    chk("R7 overflow cleared", overflow, 0);
    step(1, 13'h1ABC, 0, 0, 0, 1, "R7");
    step(0, '0, 1, 1, 0, 1, "R7 disarmed high no pop");
    chk("R7 kept word", mq.size(), 1);
    step(0, '0, 0, 0, 1, 0, "R7");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 45, 13'($urandom), $urandom_range(0, 99) < 50, $urandom_range(0, 2) != 0,
           $urandom_range(0, 199) == 0, $urandom_range(0, 3) != 0, "R3 random read");
    end
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(0, 9) != 0, 13'($urandom), $urandom_range(0, 9) < 2,
           $urandom_range(0, 1) == 1, $urandom_range(0, 499) == 0, 1, "R6 random read");
    end
    for (int i = 0; i < 600; i++) step(0, '0, 1, i[0], 0, 1, "R1 final drain");
    idle(1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule